// File: doc/BRIEF.md
# Bit-Masked Shared GPIO Port

This block is a small memory-mapped general-purpose I/O port for a processor that runs several cooperative threads on the same pins. Each pin has an output value bit and a direction bit. A third register, the access mask, is loaded before an access. While it is loaded, any write to the output value or the direction register changes only the bits the mask selects. Any read of those two registers returns only the selected bits. A thread that owns some pins sets the mask to its own bits and then writes freely. Bits that belong to other threads are never touched, so no read-modify-write sequence can race with another thread.

The processor reaches the port through a one-hot address vector with separate read and write strobes. Each register has its own address bit. A read with several address bits set returns the OR of every selected source. Reads are combinational. Writes take effect on the clock edge. Input pins pass through a two-stage synchronizer before they are read. The pad drivers and tri-state buffers sit outside this block.

Top module: `gpm_port`

## Requirements
- R1: While reset is asserted and after it is released, the mask is all ones, and the output value and direction registers are all zero (pin_out = 0, pin_oe = 0).
- R2: On a clock edge where io_wr is 1 and io_addr bit 0 (data register) is 1, the output value becomes (old & ~mask) | (io_wdata[PORT_W-1:0] & mask).
- R3: On a clock edge where io_wr is 1 and io_addr bit 1 (direction register) is 1, the direction register becomes (old & ~mask) | (io_wdata[PORT_W-1:0] & mask). pin_oe always equals the direction register.
- R4: On a clock edge where io_wr is 1 and io_addr bit 2 (mask register) is 1, the mask takes io_wdata[PORT_W-1:0] in full. A read of address bit 2 returns the mask without any masking.
- R5: A read of the data address returns the pin view ANDed with the mask. The pin view takes the output value where the direction bit is 1 and the synchronized input where it is 0. A read of the direction address returns direction ANDed with the mask. Bits at and above PORT_W of io_rdata are always zero.
- R6: When several address bits are set during a read, io_rdata is the OR of all selected sources. When io_rd is 0, io_rdata is zero.
- R7: A change on pin_in shows in the data read value two clock edges later, and not after only one edge.
- R8: When one write selects both the mask and the data or direction register, the data or direction update uses the mask value held before that edge.
- R9: A write strobe with none of the three address bits set, or an address bit without the write strobe, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | One-hot register select: bit0 data, bit1 direction, bit2 mask |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | BUS_W | Write data |
| io_rdata | output | BUS_W | Read data, combinational |
| pin_in | input | PORT_W | Raw pad inputs |
| pin_out | output | PORT_W | Output value register |
| pin_oe | output | PORT_W | Output enable (direction register) |

## Verification
The bench runs a 4-bit port and sweeps every mask against every write value, for both the data and the direction register. The model carries the prior contents forward, so each vector shows whether masked-off bits are kept and masked-on bits are replaced. Every direction pattern is crossed with every input pattern to separate pins that drive from pins that sample the synchronized input. Reads under a partial mask show that masked bits return zero. Same-edge mask-and-data writes show which mask value is used, and multi-select reads show that sources are ORed. Stray strobes, and address bits without a strobe, are checked for leaving every register unchanged.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
    // one-hot address bit positions decoded by the processor side
    localparam int unsigned GPM_ADDR_W  = 3;
    localparam int unsigned GPM_SEL_DAT = 0;
    localparam int unsigned GPM_SEL_DIR = 1;
    localparam int unsigned GPM_SEL_MSK = 2;
    localparam int unsigned GPM_NSRC    = 3;
endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = din;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs #(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dat,
    input  logic              wr_dir,
    input  logic              wr_msk,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] mask,
    output logic [PORT_W-1:0] dat,
    output logic [PORT_W-1:0] dir
);
    typedef struct packed {
        logic [PORT_W-1:0] msk;
        logic [PORT_W-1:0] dat;
        logic [PORT_W-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    // masked merge: selected bits from new data, others kept
    function automatic logic [PORT_W-1:0] merge(
        input logic [PORT_W-1:0] old_v,
        input logic [PORT_W-1:0] new_v,
        input logic [PORT_W-1:0] m
    );
        return (old_v & ~m) | (new_v & m);
    endfunction

    always_comb begin
        r_d = r_q;
        // all updates use the mask held before this edge
        if (wr_dat) r_d.dat = merge(r_q.dat, wdata, r_q.msk);
        if (wr_dir) r_d.dir = merge(r_q.dir, wdata, r_q.msk);
        if (wr_msk) r_d.msk = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.msk <= '1;
            r_q.dat <= '0;
            r_q.dir <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask = r_q.msk;
    assign dat  = r_q.dat;
    assign dir  = r_q.dir;
endmodule

// File: rtl/gpm_rdmux.sv
module gpm_rdmux
    import gpm_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned BUS_W  = 16
) (
    input  logic                  rd,
    input  logic [GPM_ADDR_W-1:0] sel,
    input  logic [PORT_W-1:0]     mask,
    input  logic [PORT_W-1:0]     dir,
    input  logic [PORT_W-1:0]     pin_view,
    output logic [BUS_W-1:0]      rdata
);
    logic [GPM_NSRC-1:0][PORT_W-1:0] src;
    logic [GPM_NSRC-1:0][PORT_W-1:0] gated;
    logic [PORT_W-1:0]               acc;

    always_comb begin
        src[GPM_SEL_DAT] = pin_view & mask;
        src[GPM_SEL_DIR] = dir & mask;
        src[GPM_SEL_MSK] = mask;
    end

    generate
        for (genvar i = 0; i < GPM_NSRC; i++) begin : g_src
            assign gated[i] = (rd && sel[i]) ? src[i] : '0;
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int i = 0; i < GPM_NSRC; i++) acc = acc | gated[i];
    end

    generate
        if (BUS_W > PORT_W) begin : g_pad
            assign rdata = {{(BUS_W-PORT_W){1'b0}}, acc};
        end else begin : g_nopad
            assign rdata = acc;
        end
    endgenerate
endmodule

// File: rtl/gpm_port.sv
module gpm_port
    import gpm_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned BUS_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GPM_ADDR_W-1:0] io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [BUS_W-1:0]      io_wdata,
    output logic [BUS_W-1:0]      io_rdata,
    input  logic [PORT_W-1:0]     pin_in,
    output logic [PORT_W-1:0]     pin_out,
    output logic [PORT_W-1:0]     pin_oe
);
    logic [PORT_W-1:0] mask_w, dat_w, dir_w, in_sync, pin_view;
    logic              wr_dat, wr_dir, wr_msk;

    assign wr_dat = io_wr && io_addr[GPM_SEL_DAT];
    assign wr_dir = io_wr && io_addr[GPM_SEL_DIR];
    assign wr_msk = io_wr && io_addr[GPM_SEL_MSK];

    generate
        if (BUS_W > PORT_W) begin : g_hi
            logic unused_wbits;
            assign unused_wbits = ^io_wdata[BUS_W-1:PORT_W];
        end
    endgenerate

    gpm_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(in_sync)
    );

    gpm_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dat(wr_dat), .wr_dir(wr_dir), .wr_msk(wr_msk),
        .wdata(io_wdata[PORT_W-1:0]),
        .mask(mask_w), .dat(dat_w), .dir(dir_w)
    );

    assign pin_view = (dir_w & dat_w) | (~dir_w & in_sync);

    gpm_rdmux #(.PORT_W(PORT_W), .BUS_W(BUS_W)) u_rd (
        .rd(io_rd), .sel(io_addr), .mask(mask_w), .dir(dir_w),
        .pin_view(pin_view), .rdata(io_rdata)
    );

    assign pin_out = dat_w;
    assign pin_oe  = dir_w;
endmodule

// File: rtl/gpm_port_chk.sv
module gpm_port_chk
    import gpm_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned BUS_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [GPM_ADDR_W-1:0] io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [BUS_W-1:0]      io_wdata,
    input logic [BUS_W-1:0]      io_rdata,
    input logic [PORT_W-1:0]     pin_out,
    input logic [PORT_W-1:0]     pin_oe,
    input logic [PORT_W-1:0]     mask
);
    // R2, R8: masked data update with the pre-edge mask
    assert_dat_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[GPM_SEL_DAT]) |=> pin_out ==
            (($past(pin_out) & ~$past(mask)) | ($past(io_wdata[PORT_W-1:0]) & $past(mask))));

    // R3: masked direction update
    assert_dir_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[GPM_SEL_DIR]) |=> pin_oe ==
            (($past(pin_oe) & ~$past(mask)) | ($past(io_wdata[PORT_W-1:0]) & $past(mask))));

    // R4: mask load is unmasked
    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[GPM_SEL_MSK]) |=> mask == $past(io_wdata[PORT_W-1:0]));

    // R9: no write strobe for a register leaves it unchanged
    assert_dat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr[GPM_SEL_DAT]) |=> $stable(pin_out));
    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr[GPM_SEL_DIR]) |=> $stable(pin_oe));
    assert_msk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr[GPM_SEL_MSK]) |=> $stable(mask));

    // R5: upper read bits are zero
    assert_rd_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata >> PORT_W) == '0);

    // R6: idle read bus
    assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0);

    // R1: registers hold reset values during reset
    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (mask == '1 && pin_out == '0 && pin_oe == '0));
endmodule

bind gpm_port gpm_port_chk #(.PORT_W(PORT_W), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .mask(mask_w)
);

// File: tb/sim_gpm_port.sv
module sim_gpm_port;
    localparam int unsigned PW = 4;
    localparam int unsigned BW = 16;
    localparam logic [2:0] A_DAT = 3'b001;
    localparam logic [2:0] A_DIR = 3'b010;
    localparam logic [2:0] A_MSK = 3'b100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    io_addr = '0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [BW-1:0] io_wdata = '0;
    logic [BW-1:0] io_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out, pin_oe;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpm_port #(.PORT_W(PW), .BUS_W(BW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [BW-1:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0; io_addr = '0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] r;
        logic [PW-1:0] mdl_dat, mdl_dir, exp_v;
        mdl_dat = '0; mdl_dir = '0;

        repeat (3) @(negedge clk);
        // R1: values while in reset
        chk("R1 out in reset", {12'h0, pin_out}, 16'h0);
        chk("R1 oe in reset",  {12'h0, pin_oe}, 16'h0);
        rst_n = 1'b1;
        rd(A_MSK, r); chk("R1 mask after reset", r, 16'h000F);
        rd(A_DAT, r); chk("R1 data after reset", r, 16'h0000);

        // R2 sweep: every mask x every value, output register
        wr(A_DIR, 16'hFFFF); mdl_dir = '1;
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 16; d++) begin
                wr(A_MSK, 16'(m));
                wr(A_DAT, 16'hFFF0 | 16'(d));
                mdl_dat = (mdl_dat & ~4'(m)) | (4'(d) & 4'(m));
                rd(A_DAT, r);
                chk("R5 masked data read", r, {12'h0, mdl_dat & 4'(m)});
                chk("R2 pin_out", {12'h0, pin_out}, {12'h0, mdl_dat});
            end
        end

        // R3 sweep: every mask x every value, direction register
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 16; d++) begin
                wr(A_MSK, 16'(m));
                wr(A_DIR, 16'(d));
                mdl_dir = (mdl_dir & ~4'(m)) | (4'(d) & 4'(m));
                rd(A_DIR, r);
                chk("R5 masked dir read", r, {12'h0, mdl_dir & 4'(m)});
                chk("R3 pin_oe", {12'h0, pin_oe}, {12'h0, mdl_dir});
            end
        end

        // R5/R7: direction x input pattern, pin view
        wr(A_MSK, 16'h000F);
        wr(A_DAT, 16'h0005); mdl_dat = 4'h5;
        for (int dr = 0; dr < 16; dr++) begin
            wr(A_DIR, 16'(dr));
            for (int pi = 0; pi < 16; pi++) begin
                @(negedge clk); pin_in = 4'(pi);
                repeat (2) @(negedge clk);
                rd(A_DAT, r);
                exp_v = (4'(dr) & mdl_dat) | (~4'(dr) & 4'(pi));
                chk("R5 pin view", r, {12'h0, exp_v});
            end
        end
        mdl_dir = 4'hF;

        // R7: latency of the input path
        wr(A_DIR, 16'h0000); mdl_dir = '0;
        @(negedge clk); pin_in = 4'h0;
        repeat (3) @(negedge clk);
        pin_in = 4'hA;
        @(negedge clk);       // one edge
        io_addr = A_DAT; io_rd = 1'b1; #1;
        chk("R7 after one edge", io_rdata, 16'h0000);
        @(negedge clk);       // two edges
        #1 chk("R7 after two edges", io_rdata, 16'h000A);
        io_rd = 1'b0; io_addr = '0;

        // R8: mask and data in one write use the old mask
        wr(A_DIR, 16'h000F); mdl_dir = 4'hF;
        wr(A_DAT, 16'h0000);
        wr(A_MSK, 16'h0003);
        wr(A_MSK | A_DAT, 16'h000F);
        chk("R8 data uses old mask", {12'h0, pin_out}, 16'h0003);
        rd(A_MSK, r); chk("R8 mask loaded", r, 16'h000F);
        wr(A_MSK, 16'h0001);
        wr(A_MSK | A_DIR, 16'h0000);
        chk("R8 dir uses old mask", {12'h0, pin_oe}, 16'h000E);

        // R9: strobe without address bit, address bits without strobe
        wr(A_MSK, 16'h000F);
        wr(3'b000, 16'hFFFF);
        @(negedge clk); io_addr = 3'b111; io_wdata = 16'h0009;
        @(negedge clk); io_addr = '0; io_wdata = '0;
        chk("R9 out held", {12'h0, pin_out}, 16'h0003);
        chk("R9 oe held", {12'h0, pin_oe}, 16'h000E);
        rd(A_MSK, r); chk("R9 mask held", r, 16'h000F);

        // R6: multi-select read is OR, idle read is zero
        wr(A_MSK, 16'h0006);
        rd(A_MSK | A_DIR, r);
        chk("R6 OR of mask and dir", r, 16'h0006 | (16'h000E & 16'h0006));
        rd(A_MSK | A_DAT, r);
        exp_v = ((4'hE & 4'h3) | (~4'hE & pin_in)) & 4'h6;
        chk("R6 OR of mask and data", r, 16'h0006 | {12'h0, exp_v});
        @(negedge clk); io_addr = 3'b111; io_rd = 1'b0;
        #1 chk("R6 idle read", io_rdata, 16'h0000);
        io_addr = '0;

        // R1: reset restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_MSK, r); chk("R1 mask re-reset", r, 16'h000F);
        chk("R1 oe re-reset", {12'h0, pin_oe}, 16'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule